// File: doc/BRIEF.md
# Serial Tile Frame Broadcaster

This block keeps a small on-chip frame store and streams its contents, tile by tile, on a single serial line. Each tile occupies nine consecutive bytes: one identifier byte followed by eight row bytes, with rows 0 to 7 in ascending address order. Within a row byte, bit 7 is column 7 and bit 0 is column 0. A set bit is a lit pixel. For every tile the block emits a framing byte of all ones, then the identifier, then the eight rows, most significant bit first, one bit per clock.

After each tile record the line rests low for a fixed number of bit times, then the next tile follows. Output begins with the tile whose identifier sits at address 0. After the tile at the last configured base, the block wraps to address 0 and carries on without end. A mode level is passed to the receivers through a register, and it has no influence on the stream. A plain write port lets the store be loaded or changed at any time. New contents appear in the next record read from the changed location.

Top module: `tilecast_top`

## Requirements
- R1: When `wr_en` is high at a rising edge, `wr_data` is stored at `wr_addr`. A tile whose base address is b keeps its identifier at b and row r (r = 0..7) at b+1+r. Every later record of that tile carries the stored values.
- R2: Each tile record is 10 bytes, 80 bits in all: 0xFF, then the identifier, then rows 0 to 7 in that order.
- R3: Each byte goes out most significant bit first. The line changes by exactly one bit per rising clock edge while a record is sent.
- R4: Between the last bit of one record and the first bit of the next, the line is low for exactly `GAP_BITS` clock cycles (default 100).
- R5: The first record after reset is the tile at base 0. Each following record is the tile whose base is 9 higher.
- R6: After the record of the tile at base `LAST_BASE` (default 18), the next record is the tile at base 0, and the cycle repeats indefinitely.
- R7: `tx_line` is low while `rst_n` is low. After `rst_n` rises, the line stays low through the first rising edge and is high (first framing bit) after the second rising edge.
- R8: `mode_out` is low in reset and otherwise equals `mode_in` from one cycle earlier. The serial stream does not depend on `mode_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one line bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_in | input | 1 | Mode level to forward to receivers |
| wr_en | input | 1 | Frame store write strobe |
| wr_addr | input | ADDR_W | Frame store write address |
| wr_data | input | DATA_W | Frame store write data |
| tx_line | output | 1 | Serial tile stream |
| mode_out | output | 1 | Registered copy of `mode_in` |

## Verification
Suppose the byte counter or the bit counter holds a wrong value. The record on `tx_line` then has the wrong length. The error shows as a misplaced framing byte, or as an idle gap that is too short or too long, within one record of about 180 cycles. Suppose instead the tile base address is wrong. The identifier byte of the very next record is then wrong, and a bad wrap shows once the last tile has been sent. Suppose finally the gap timer is off by any amount. The low run measured between the last row bit and the next framing byte is then off by the same number of cycles.

// File: rtl/tilecast_pkg.sv
// Shared types and fixed layout constants for the serial tile broadcaster.
// Assumes tiles of one identifier byte plus eight row bytes.
package tilecast_pkg;

    // Control states of the broadcaster sequencer
    typedef enum logic [2:0] {
        ST_INIT    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_START   = 3'd2,
        ST_LASTBIT = 3'd3,
        ST_BYTE    = 3'd4,
        ST_PAUSE   = 3'd5
    } tc_state_e;

    localparam int ROWS_PER_TILE = 8;
    localparam int TILE_BYTES    = ROWS_PER_TILE + 1;

endpackage

// File: rtl/tilecast_store.sv
// Frame store: one synchronous write port, one combinational read port.
// Assumes the contents need no reset; they are loaded through the write port.
module tilecast_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the write data on a strobed edge
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/tilecast_shifter.sv
// Byte serializer: parallel load, MSB-first shift, bit position counter.
// Assumes load and shift are never asserted together.
module tilecast_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift,
    output logic              msb,
    output logic              pre_last,
    output logic [$clog2(DATA_W)-1:0] bit_idx
);
    localparam int BIT_W = $clog2(DATA_W);

    logic [DATA_W-1:0] sh_q;
    logic [BIT_W-1:0]  cnt_q;

    // Load a new byte or move the next bit into the MSB position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= load_val;
            cnt_q <= '0;
        end else if (shift) begin
            sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign msb      = sh_q[DATA_W-1];
    assign pre_last = (cnt_q == BIT_W'(DATA_W - 2));
    assign bit_idx  = cnt_q;

endmodule

// File: rtl/tilecast_gap.sv
// Idle gap timer: counts cycles while running, flags the final pause cycle.
// Assumes the sequencer spends one extra low cycle in setup, so the
// pause itself lasts GAP_BITS-1 cycles.
module tilecast_gap #(
    parameter int GAP_BITS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(GAP_BITS);

    logic [CNT_W-1:0] cnt_q;

    // Count while running, hold at zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == CNT_W'(GAP_BITS - 2));

endmodule

// File: rtl/tilecast_top.sv
// Serial tile broadcaster top: sequencer, tile address counter, and the
// store, serializer and gap timer. Sends 0xFF, id, rows 0..7 per tile, then a
// low gap, cycling through tile bases 0, 9, ... LAST_BASE forever.
// Assumes LAST_BASE is a multiple of 9 and GAP_BITS >= 2.
module tilecast_top
    import tilecast_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter int              DATA_W     = 8,
    parameter int              LAST_BASE  = 18,
    parameter int              GAP_BITS   = 100,
    parameter logic [DATA_W-1:0] START_CODE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_line,
    output logic              mode_out
);
    localparam int IDX_W = $clog2(TILE_BYTES + 1);
    localparam int BIT_W = $clog2(DATA_W);

    tc_state_e         state;
    logic [ADDR_W-1:0] base;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              sh_load;
    logic              sh_shift;
    logic [DATA_W-1:0] sh_val;
    logic              sh_msb;
    logic              sh_pre_last;
    logic [BIT_W-1:0]  bit_idx;
    logic              gap_done;
    logic              rec_done;

    assign rec_done = (idx == IDX_W'(TILE_BYTES));
    assign rd_addr  = base + ADDR_W'(idx);
    assign sh_load  = (state == ST_SETUP) || (state == ST_LASTBIT && !rec_done);
    assign sh_shift = (state == ST_START) || (state == ST_BYTE);
    assign sh_val   = (state == ST_SETUP) ? START_CODE : rd_data;

    tilecast_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    tilecast_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (sh_val),
        .shift    (sh_shift),
        .msb      (sh_msb),
        .pre_last (sh_pre_last),
        .bit_idx  (bit_idx)
    );

    tilecast_gap #(.GAP_BITS(GAP_BITS)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_PAUSE),
        .done  (gap_done)
    );

    // Sequence framing byte, tile bytes and gap; advance and wrap the tile base
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_INIT;
            base  <= '0;
            idx   <= '0;
        end else begin
            case (state)
                ST_INIT: state <= ST_SETUP;
                ST_SETUP: begin
                    state <= ST_START;
                    idx   <= '0;
                end
                ST_START, ST_BYTE: begin
                    if (sh_pre_last) begin
                        state <= ST_LASTBIT;
                    end
                end
                ST_LASTBIT: begin
                    if (rec_done) begin
                        state <= ST_PAUSE;
                    end else begin
                        state <= ST_BYTE;
                        idx   <= idx + 1'b1;
                    end
                end
                ST_PAUSE: begin
                    if (gap_done) begin
                        state <= ST_SETUP;
                        base  <= (base == ADDR_W'(LAST_BASE)) ? '0
                               : base + ADDR_W'(TILE_BYTES);
                    end
                end
                default: state <= ST_INIT;
            endcase
        end
    end

    // Forward the mode level to the receivers one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_out <= 1'b0;
        end else begin
            mode_out <= mode_in;
        end
    end

    assign tx_line = (state == ST_START || state == ST_BYTE || state == ST_LASTBIT)
                     ? sh_msb : 1'b0;

endmodule

// File: rtl/tilecast_chk.sv
// Property checker for the serial tile broadcaster, bound to tilecast_top.
module tilecast_chk
    import tilecast_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter int              DATA_W     = 8,
    parameter int              LAST_BASE  = 18,
    parameter logic [DATA_W-1:0] START_CODE = '1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      mode_in,
    input logic                      mode_out,
    input logic                      tx_line,
    input tc_state_e                 state,
    input logic [ADDR_W-1:0]         base,
    input logic [$clog2(DATA_W)-1:0] bit_idx
);

    // R7
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !tx_line);

    // R4
    pause_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PAUSE |-> !tx_line);

    // R2
    frame_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SETUP |=> (state == ST_START && tx_line == START_CODE[DATA_W-1]));

    // R3
    last_bit_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LASTBIT |-> bit_idx == DATA_W - 1);

    // R6
    base_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base <= ADDR_W'(LAST_BASE)) && (base % TILE_BYTES == 0));

    // R5
    base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(base) |-> (base == '0 || base == $past(base) + ADDR_W'(TILE_BYTES)));

    // R8
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> mode_out == $past(mode_in));

endmodule

bind tilecast_top tilecast_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LAST_BASE  (LAST_BASE),
    .START_CODE (START_CODE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_in  (mode_in),
    .mode_out (mode_out),
    .tx_line  (tx_line),
    .state    (state),
    .base     (base),
    .bit_idx  (bit_idx)
);

// File: tb/sim_tilecast_top.sv
// Directed bench for tilecast_top: preloads three tiles, then checks records,
// gaps, wrap order, a live store write and the mode forwarding.
module sim_tilecast_top;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int GAP      = 100;
    localparam int NTILES   = 3;
    localparam int NBYTES   = NTILES * 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_in = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              tx_line;
    logic              mode_out;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [7:0] model [NBYTES];

    tilecast_top u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_in  (mode_in),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tx_line  (tx_line),
        .mode_out (mode_out)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_byte(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R1 R7: preload under reset, quiet line, start timing after release
    task automatic t_reset();
        for (int i = 0; i < NBYTES; i++) begin
            model[i] = 8'((i * 8'h47) ^ 8'h2B);
        end
        model[0] = 8'h5A; model[9] = 8'hA5; model[18] = 8'h3C;
        model[1] = 8'h80; model[2] = 8'h01; model[8] = 8'h00; model[12] = 8'hFF;
        rst_n = 1'b0;
        for (int i = 0; i < NBYTES; i++) write_byte(i, model[i]);
        @(negedge clk);
        check(tx_line == 1'b0, "R7 line low in reset", 128'(tx_line), 0);
        check(mode_out == 1'b0, "R8 mode_out low in reset", 128'(mode_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_line == 1'b0, "R7 low after first edge", 128'(tx_line), 0);
        @(negedge clk);
        check(tx_line == 1'b1, "R7 high after second edge", 128'(tx_line), 1);
    endtask

    // R2 R3 R5 R6 R4: read one record (current sample is its first bit), then its gap
    task automatic t_record(input int tile, input string tag);
        logic [79:0] got = '0;
        logic [79:0] exp = '0;
        int zeros = 0;
        exp = {72'(0), 8'hFF};
        for (int k = 0; k < 9; k++) exp = {exp[71:0], model[tile*9 + k]};
        got = {79'(0), tx_line};
        for (int i = 1; i < 80; i++) begin
            @(negedge clk);
            got = {got[78:0], tx_line};
        end
        check(got == exp, tag, 128'(got), 128'(exp));
        @(negedge clk);
        while (tx_line == 1'b0 && zeros < 400) begin
            zeros++;
            @(negedge clk);
        end
        check(zeros == GAP, "R4 gap length", 128'(zeros), 128'(GAP));
    endtask

    // R1: change a row of tile 2 while tile 1 is being sent
    task automatic t_live_write();
        fork
            t_record(1, "R5 record tile1");
            begin
                model[18 + 1 + 5] = 8'hC6;
                write_byte(18 + 1 + 5, 8'hC6);
            end
        join
    endtask

    // R8: toggle mode through a whole record; stream must be unaffected
    task automatic t_mode_toggle();
        fork
            t_record(2, "R8 R1 record tile2 under mode toggling");
            begin
                logic prev = mode_in;
                for (int i = 0; i < 40; i++) begin
                    @(negedge clk);
                    check(mode_out == prev, "R8 mode_out follows", 128'(mode_out), 128'(prev));
                    mode_in = ((i % 3) == 1) ? 1'b0 : ~mode_in;
                    prev = mode_in;
                end
            end
        join
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_record(0, "R2 R3 R5 record tile0");
        t_record(1, "R5 record tile1");
        t_record(2, "R5 record tile2");
        t_record(0, "R6 wrap to tile0");
        t_live_write();
        t_mode_toggle();
        t_record(0, "R6 second wrap to tile0");
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule